// File: doc/BRIEF.md
# Dual-Processor Mailbox With Sticky Error Flags

This block links two processors with a pair of word-wide queues, one per direction. Each processor has its own access lane into the same small register window. The lane a request arrives on identifies the requester, and that identity picks the queue behind each register. A processor pushes words to its partner by writing the send register. It pops words sent to it by reading the receive register. A status register shows whether incoming data is waiting and whether the outgoing queue has room. The same register holds two sticky error flags, one for each kind of misuse.

Each queue has a three-state controller, `fifo_state_e`, with these states:
- FIFO_EMPTY. On a push (fill) it moves to FIFO_PARTIAL, or to FIFO_FULL when the depth is 1.
- FIFO_PARTIAL. A push with no pop that takes the last free slot (top-off) moves it to FIFO_FULL. A pop with no push that takes the last entry (drain) moves it to FIFO_EMPTY.
- FIFO_FULL. A pop with no push (release) moves it back to FIFO_PARTIAL.

A push and a pop in the same cycle (pass-through) keep the current state. A separate decoder sorts each lane's request into one of these access kinds: `ACC_NONE`, `ACC_ID_RD`, `ACC_ST_RD`, `ACC_ST_WR`, `ACC_DATA_WR` or `ACC_DATA_RD`.

Each processor has an interrupt line. It stays high while that processor has incoming words waiting or while either of its error flags is set.

Top module: `ipc_mailbox`

## Requirements
- R1: A read of offset 0x000 returns the index of the lane that made the request (0 or 1).
- R2: In the status word at offset 0x050, bit 0 is 1 while the requester's incoming queue holds data, and bit 1 is 1 while its outgoing queue has a free slot. A word written by one side shows in the other side's bit 0 in the next cycle.
- R3: A word written to offset 0x054 enters the writer's outgoing queue. Words come out at the partner's offset 0x058 in write order. The queue holds up to DEPTH (default 8) words.
- R4: A write to offset 0x054 while the outgoing queue is full, with no pop of that queue in the same cycle, is discarded. It sets the writer's sticky status bit 2.
- R5: A read of offset 0x058 while the incoming queue is empty returns 0. It sets the reader's sticky status bit 3.
- R6: Any write to offset 0x050 clears bits 2 and 3 for the writing side only.
- R7: Interrupt line k is high exactly while side k's incoming queue is non-empty or either of side k's sticky bits is set.
- R8: A read of offset 0x058 returns the head word in the same cycle and removes it at that clock edge.
- R9: When one side pushes and the other pops the same queue in one cycle, the occupancy is unchanged. Such a push is accepted even when the queue was full, and no error is flagged.
- R10: After reset both queues are empty, all sticky bits are 0, both interrupts are low, and status reads 0x2.
- R11: Reads of any other offset return 0. Writes to any other offset, to 0x000 or to 0x058 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 2 | Per-lane request valid; bit k belongs to processor k |
| acc_write | input | 2 | Per-lane write (1) or read (0) |
| acc_addr | input | 2*ADDR_W | Per-lane byte offset; lane k in bits [k*ADDR_W +: ADDR_W] |
| acc_wdata | input | 2*DATA_W | Per-lane write data |
| acc_rdata | output | 2*DATA_W | Per-lane read data, valid in the cycle of the request |
| irq | output | 2 | Per-processor interrupt |

## Verification
The assertions check these properties on every cycle:
- The queue controller's state matches its occupancy.
- No pop is ever issued to an empty queue, and no push to a full queue unless a pop happens in the same cycle.
- A push and a pop together leave the occupancy unchanged.
- Sticky flags hold until cleared, and a clear empties them.
- A push raises the partner's interrupt in the next cycle.

Only the bench scenarios show the data-side behaviour:
- Words come out in order and a discarded word never appears.
- Reads from an empty queue return 0, and unmapped offsets are inert.
- A clear by one side leaves the other side's flags alone.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

    // Register offsets (byte addresses within the shared window)
    localparam logic [11:0] OFS_WHOAMI = 12'h000;
    localparam logic [11:0] OFS_STATUS = 12'h050;
    localparam logic [11:0] OFS_SEND   = 12'h054;
    localparam logic [11:0] OFS_RECV   = 12'h058;

    // Status word bit positions
    localparam int unsigned ST_AVAIL   = 0;
    localparam int unsigned ST_ROOM    = 1;
    localparam int unsigned ST_WFULL   = 2;
    localparam int unsigned ST_RDEMPTY = 3;
    localparam int unsigned ST_BITS    = 4;

    typedef enum logic [1:0] {
        FIFO_EMPTY   = 2'd0,
        FIFO_PARTIAL = 2'd1,
        FIFO_FULL    = 2'd2
    } fifo_state_e;

    typedef enum logic [2:0] {
        ACC_NONE    = 3'd0,
        ACC_ID_RD   = 3'd1,
        ACC_ST_RD   = 3'd2,
        ACC_ST_WR   = 3'd3,
        ACC_DATA_WR = 3'd4,
        ACC_DATA_RD = 3'd5
    } acc_kind_e;

endpackage

// File: rtl/mbox_lane_decode.sv
module mbox_lane_decode
    import ipc_mbox_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    output acc_kind_e         kind_o
);

    localparam logic [ADDR_W-1:0] A_WHOAMI = ADDR_W'(OFS_WHOAMI);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_SEND   = ADDR_W'(OFS_SEND);
    localparam logic [ADDR_W-1:0] A_RECV   = ADDR_W'(OFS_RECV);

    always_comb begin
        kind_o = ACC_NONE;
        if (valid_i) begin
            unique case ({write_i, addr_i})
                {1'b0, A_WHOAMI}: kind_o = ACC_ID_RD;
                {1'b0, A_STATUS}: kind_o = ACC_ST_RD;
                {1'b1, A_STATUS}: kind_o = ACC_ST_WR;
                {1'b1, A_SEND}:   kind_o = ACC_DATA_WR;
                {1'b0, A_RECV}:   kind_o = ACC_DATA_RD;
                default:          kind_o = ACC_NONE;
            endcase
        end
    end

endmodule

// File: rtl/mbox_fifo.sv
module mbox_fifo
    import ipc_mbox_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] head_o,
    output logic              empty_o,
    output logic              full_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    fifo_state_e       state_q, state_d;
    logic [CNT_W-1:0]  count_q, count_d;
    logic [PTR_W-1:0]  wptr_q, rptr_q;
    logic [DATA_W-1:0] mem [DEPTH];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FIFO_EMPTY: begin
                if (push_i) state_d = (DEPTH == 1) ? FIFO_FULL : FIFO_PARTIAL;  // fill
            end
            FIFO_PARTIAL: begin
                if (push_i && !pop_i && count_q == CNT_TOP)
                    state_d = FIFO_FULL;                                         // top-off
                else if (pop_i && !push_i && count_q == CNT_ONE)
                    state_d = FIFO_EMPTY;                                        // drain
            end
            FIFO_FULL: begin
                if (pop_i && !push_i)
                    state_d = (DEPTH == 1) ? FIFO_EMPTY : FIFO_PARTIAL;          // release
            end
            default: state_d = FIFO_EMPTY;
        endcase
    end

    always_comb begin
        count_d = count_q;
        if (push_i && !pop_i) count_d = count_q + CNT_ONE;
        else if (pop_i && !push_i) count_d = count_q - CNT_ONE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FIFO_EMPTY;
            count_q <= '0;
            wptr_q  <= '0;
            rptr_q  <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (push_i) wptr_q <= (wptr_q == PTR_LAST) ? '0 : wptr_q + PTR_W'(1);
            if (pop_i)  rptr_q <= (rptr_q == PTR_LAST) ? '0 : rptr_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) mem[wptr_q] <= wdata_i;
    end

    // Outputs
    always_comb begin
        empty_o = 1'b0;
        full_o  = 1'b0;
        unique case (state_q)
            FIFO_EMPTY:   empty_o = 1'b1;
            FIFO_PARTIAL: ;
            FIFO_FULL:    full_o = 1'b1;
            default:      empty_o = 1'b1;
        endcase
        head_o = mem[rptr_q];
    end

    assert_state_matches_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == FIFO_EMPTY) == (count_q == '0)) &&
        ((state_q == FIFO_FULL) == (count_q == CNT_W'(DEPTH))));

    assert_no_push_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (!full_o || pop_i));

    assert_no_pop_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

    assert_occupancy_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> (count_q == $past(count_q)));

endmodule

// File: rtl/mbox_side_flags.sv
module mbox_side_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_wfull_i,
    input  logic set_rdempty_i,
    input  logic clear_i,
    input  logic incoming_ready_i,
    output logic wfull_o,
    output logic rdempty_o,
    output logic irq_o
);

    logic wfull_q, rdempty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wfull_q   <= 1'b0;
            rdempty_q <= 1'b0;
        end else if (clear_i) begin
            wfull_q   <= 1'b0;
            rdempty_q <= 1'b0;
        end else begin
            if (set_wfull_i)   wfull_q   <= 1'b1;
            if (set_rdempty_i) rdempty_q <= 1'b1;
        end
    end

    always_comb begin
        wfull_o   = wfull_q;
        rdempty_o = rdempty_q;
        irq_o     = incoming_ready_i | wfull_q | rdempty_q;
    end

    assert_wfull_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wfull_o && !clear_i) |=> wfull_o);

    assert_rdempty_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdempty_o && !clear_i) |=> rdempty_o);

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!wfull_o && !rdempty_o));

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            acc_valid,
    input  logic [1:0]            acc_write,
    input  logic [2*ADDR_W-1:0]   acc_addr,
    input  logic [2*DATA_W-1:0]   acc_wdata,
    output logic [2*DATA_W-1:0]   acc_rdata,
    output logic [1:0]            irq
);

    localparam int SIDES = 2;

    acc_kind_e         kind  [SIDES];
    logic [DATA_W-1:0] head  [SIDES];
    logic [SIDES-1:0]  q_empty, q_full, q_push, q_pop;
    logic [SIDES-1:0]  wfull, rdempty;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int OTHER = 1 - s;

        logic [ST_BITS-1:0] status;

        mbox_lane_decode #(.ADDR_W(ADDR_W)) u_dec (
            .valid_i (acc_valid[s]),
            .write_i (acc_write[s]),
            .addr_i  (acc_addr[s*ADDR_W +: ADDR_W]),
            .kind_o  (kind[s])
        );

        // Queue s carries words from side s to side OTHER
        always_comb begin
            q_pop[s]  = (kind[OTHER] == ACC_DATA_RD) && !q_empty[s];
            q_push[s] = (kind[s] == ACC_DATA_WR) && (!q_full[s] || q_pop[s]);
        end

        mbox_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (q_push[s]),
            .pop_i   (q_pop[s]),
            .wdata_i (acc_wdata[s*DATA_W +: DATA_W]),
            .head_o  (head[s]),
            .empty_o (q_empty[s]),
            .full_o  (q_full[s])
        );

        mbox_side_flags u_flags (
            .clk              (clk),
            .rst_n            (rst_n),
            .set_wfull_i      ((kind[s] == ACC_DATA_WR) && !q_push[s]),
            .set_rdempty_i    ((kind[s] == ACC_DATA_RD) && q_empty[OTHER]),
            .clear_i          (kind[s] == ACC_ST_WR),
            .incoming_ready_i (!q_empty[OTHER]),
            .wfull_o          (wfull[s]),
            .rdempty_o        (rdempty[s]),
            .irq_o            (irq[s])
        );

        always_comb begin
            status             = '0;
            status[ST_AVAIL]   = !q_empty[OTHER];
            status[ST_ROOM]    = !q_full[s];
            status[ST_WFULL]   = wfull[s];
            status[ST_RDEMPTY] = rdempty[s];
        end

        always_comb begin
            unique case (kind[s])
                ACC_ID_RD:   acc_rdata[s*DATA_W +: DATA_W] = DATA_W'(s);
                ACC_ST_RD:   acc_rdata[s*DATA_W +: DATA_W] = DATA_W'(status);
                ACC_DATA_RD: acc_rdata[s*DATA_W +: DATA_W] =
                                 q_empty[OTHER] ? '0 : head[OTHER];
                default:     acc_rdata[s*DATA_W +: DATA_W] = '0;
            endcase
        end

        assert_push_raises_partner_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
            q_push[s] |=> irq[OTHER]);

        assert_push_visible_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
            q_push[s] |=> !q_empty[s]);
    end

endmodule

// File: tb/ipc_mailbox_bench.sv
module ipc_mailbox_bench;

    localparam int AW = 12;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      acc_valid = '0;
    logic [1:0]      acc_write = '0;
    logic [2*AW-1:0] acc_addr = '0;
    logic [2*DW-1:0] acc_wdata = '0;
    logic [2*DW-1:0] acc_rdata;
    logic [1:0]      irq;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    ipc_mailbox u_ipc_mailbox (
        .clk, .rst_n, .acc_valid, .acc_write, .acc_addr, .acc_wdata, .acc_rdata, .irq
    );

    typedef struct packed {
        logic        lane;
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic        chk;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // Walked in order from a freshly reset block
    localparam vec_t TABLE [0:18] = '{
        '{1'b0, 1'b0, 12'h000, 32'h0,          1'b1, 32'h0,          4'd1},  // R1
        '{1'b1, 1'b0, 12'h000, 32'h0,          1'b1, 32'h1,          4'd1},  // R1
        '{1'b0, 1'b0, 12'h050, 32'h0,          1'b1, 32'h2,          4'd10}, // R10
        '{1'b0, 1'b1, 12'h054, 32'hA5A5_0001,  1'b0, 32'h0,          4'd3},
        '{1'b1, 1'b0, 12'h050, 32'h0,          1'b1, 32'h3,          4'd2},  // R2
        '{1'b0, 1'b1, 12'h054, 32'h0000_0002,  1'b0, 32'h0,          4'd3},
        '{1'b1, 1'b0, 12'h058, 32'h0,          1'b1, 32'hA5A5_0001,  4'd3},  // R3
        '{1'b1, 1'b0, 12'h058, 32'h0,          1'b1, 32'h2,          4'd8},  // R8
        '{1'b1, 1'b0, 12'h050, 32'h0,          1'b1, 32'h2,          4'd8},  // R8
        '{1'b1, 1'b0, 12'h058, 32'h0,          1'b1, 32'h0,          4'd5},  // R5
        '{1'b1, 1'b0, 12'h050, 32'h0,          1'b1, 32'hA,          4'd5},  // R5
        '{1'b0, 1'b0, 12'h050, 32'h0,          1'b1, 32'h2,          4'd6},  // R6 other side clean
        '{1'b1, 1'b1, 12'h050, 32'hFFFF_FFFF,  1'b0, 32'h0,          4'd6},
        '{1'b1, 1'b0, 12'h050, 32'h0,          1'b1, 32'h2,          4'd6},  // R6
        '{1'b1, 1'b1, 12'h0F0, 32'h0000_DEAD,  1'b0, 32'h0,          4'd11},
        '{1'b0, 1'b0, 12'h050, 32'h0,          1'b1, 32'h2,          4'd11}, // R11 nothing queued
        '{1'b1, 1'b0, 12'h0F0, 32'h0,          1'b1, 32'h0,          4'd11}, // R11
        '{1'b1, 1'b1, 12'h054, 32'h0000_1234,  1'b0, 32'h0,          4'd2},
        '{1'b0, 1'b0, 12'h058, 32'h0,          1'b1, 32'h0000_1234,  4'd2}   // R2 reverse direction
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic access(input int lane, input logic wr, input logic [11:0] a,
                          input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        acc_valid[lane] = 1'b1;
        acc_write[lane] = wr;
        acc_addr[lane*AW +: AW] = a;
        acc_wdata[lane*DW +: DW] = d;
        #1;
        rd = acc_rdata[lane*DW +: DW];
        @(posedge clk);
        #1;
        acc_valid = '0;
    endtask

    // Lane 0 writes the send register while lane 1 reads the receive register
    task automatic push_and_pop(input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        acc_valid = 2'b11;
        acc_write = 2'b01;
        acc_addr  = {12'h058, 12'h054};
        acc_wdata = {32'h0, d};
        #1;
        rd = acc_rdata[DW +: DW];
        @(posedge clk);
        #1;
        acc_valid = '0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R10 irq after reset", {30'h0, irq}, 32'h0);

        foreach (TABLE[i]) begin
            access(int'(TABLE[i].lane), TABLE[i].wr, TABLE[i].addr, TABLE[i].wdata, rd);
            if (TABLE[i].chk)
                check($sformatf("R%0d vector %0d", TABLE[i].req, i), rd, TABLE[i].exp);
        end

        // R7: interrupt follows incoming data
        access(0, 1'b1, 12'h054, 32'h55, rd);
        check("R7 irq after push", {30'h0, irq}, 32'h2);
        access(1, 1'b0, 12'h058, 32'h0, rd);
        check("R7 irq after pop", {30'h0, irq}, 32'h0);

        // R3: fill queue 0 to its depth
        for (int k = 0; k < 8; k++) access(0, 1'b1, 12'h054, 32'h100 + k, rd);
        access(0, 1'b0, 12'h050, 32'h0, rd);
        check("R3 full status", rd, 32'h0);

        // R4: overflow discarded and flagged
        access(0, 1'b1, 12'h054, 32'h99, rd);
        access(0, 1'b0, 12'h050, 32'h0, rd);
        check("R4 overflow flag", rd, 32'h4);
        check("R7 irq from flag", {30'h0, irq}, 32'h3);
        access(0, 1'b1, 12'h050, 32'h0, rd);
        access(0, 1'b0, 12'h050, 32'h0, rd);
        check("R6 cleared", rd, 32'h0);
        check("R7 irq after clear", {30'h0, irq}, 32'h2);

        // R9: push into a full queue while it is popped
        push_and_pop(32'h77, rd);
        check("R9 pop head", rd, 32'h100);
        access(0, 1'b0, 12'h050, 32'h0, rd);
        check("R9 still full, no flag", rd, 32'h0);

        for (int k = 1; k < 8; k++) begin
            access(1, 1'b0, 12'h058, 32'h0, rd);
            check("R3 order", rd, 32'h100 + k);
        end
        access(1, 1'b0, 12'h058, 32'h0, rd);
        check("R9 accepted word last", rd, 32'h77);
        access(1, 1'b0, 12'h050, 32'h0, rd);
        check("R4 discarded word absent", rd, 32'h2);
        check("R7 irq drained", {30'h0, irq}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule